// File: doc/BRIEF.md
# Segment and Page Access Guard

This block decides, before a memory cycle is launched, whether one access may proceed. Each request carries the running code's privilege ring, the ring written into the selector that names the segment, a cached copy of the segment's descriptor (class bits, descriptor ring, limit, granularity flag and present flag), the byte offset, the access length, and the access kind. It also carries the user and writable flags of the page table entry that maps the access. The guard answers one clock later with a grant or with a fault and a cause code, and the memory pipeline uses that answer to either issue the cycle or raise a protection exception.

Segment rules come first. The segment must be present. Its class must allow the kind of access. The effective ring, which is the less trusted of the selector ring and the running ring, must be no less trusted than the descriptor ring. The last byte touched must lie within the limit, and that limit is scaled by 4 KB when the granularity flag is set. Only when all of these pass, and paging is switched on, does the user/supervisor page rule apply. A lower numbered ring is more trusted. Rings 0, 1 and 2 act as supervisor, and ring 3 acts as user.

Top module: `seg_page_guard`

## Requirements
- R1: A request with `req_valid` high is answered exactly one clock later with `rsp_valid` high. `rsp_valid` is low in every cycle that follows a cycle without a request, and `rsp_grant` and `rsp_cause` then keep their previous values.
- R2: The effective ring is the numerically larger of `req_cpl` and `req_rpl`. When it is numerically greater than `seg_dpl`, the access is refused with cause 3 (privilege).
- R3: `seg_type` bit 2 set marks a system segment, and any access to it is refused. Bit 1 marks code and bit 0 is the permission bit: writable for data, readable for code. Kind encoding is 0 read, 1 write, 2 fetch, and 3 is reserved and always refused. A read of code needs bit 0. A write needs a data segment with bit 0 set. A fetch needs code. Any violation gives cause 2 (type).
- R4: With `seg_gran` = 0 the limit is a byte count. The access passes only when `req_offset` + `req_len` (length minus one, 0..3) is no greater than `seg_limit`. Otherwise the cause is 4 (limit).
- R5: With `seg_gran` = 1 the effective limit is `seg_limit` shifted left by 12 with the low 12 bits set to one. The last-byte sum is formed without wrap-around, so an access that carries past the top of the address space faults with cause 4.
- R6: A clear `seg_present` gives cause 1 (not present), which outranks every other cause.
- R7: Causes are ranked not-present, then type, then privilege, then limit, then page. A segment fault hides any page fault.
- R8: With paging on and `req_cpl` = 3, a page with `pte_user` = 0 is refused with cause 5. Rings 0 to 2 may use both user and supervisor pages.
- R9: With paging on, a ring-3 write to a page with `pte_write` = 0 gives cause 6. Supervisor writes ignore `pte_write`.
- R10: With `paging_en` low, the page flags have no effect and causes 5 and 6 never appear.
- R11: During and after reset, before any request, `rsp_valid` and `rsp_grant` are 0 and `rsp_cause` is 0. `rsp_grant` is 1 exactly when the answered cause is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_cpl | input | 2 | Ring of the running code |
| req_rpl | input | 2 | Ring carried by the selector |
| seg_dpl | input | 2 | Ring stored in the descriptor |
| seg_type | input | 3 | Segment class bits: system, code, permission |
| seg_present | input | 1 | Descriptor present flag |
| seg_gran | input | 1 | Limit granularity: 0 bytes, 1 4 KB units |
| seg_limit | input | 20 | Raw segment limit |
| req_offset | input | 32 | Byte offset within the segment |
| req_len | input | 2 | Access length minus one |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 reserved |
| paging_en | input | 1 | Page rules enabled |
| pte_user | input | 1 | Page reachable from ring 3 |
| pte_write | input | 1 | Page writable from ring 3 |
| rsp_valid | output | 1 | Answer for the previous cycle's request |
| rsp_grant | output | 1 | Access may proceed |
| rsp_cause | output | 3 | 0 none, 1 not present, 2 type, 3 privilege, 4 limit, 5 user page, 6 read-only page |

## Verification
The bench aims at the limit edges: the last permitted byte with one, two and four byte lengths, the same edges with 4 KB scaling, and an offset that carries past the top of the address space. A guard that compared only the offset, or that let the sum wrap, would grant these accesses. The bench also pairs several faults in one request, such as a not-present segment with an out-of-range offset, or a privilege fault on a supervisor-only page. A wrong priority shows up there as a wrong cause code. It further tries a selector ring that is less trusted than the running ring, supervisor writes to read-only pages, and user faults sent while paging is off. A design that used the running ring alone, applied the writable flag in every ring, or ignored the paging switch would refuse or grant the wrong requests.

// File: rtl/guard_pkg.sv
package guard_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [2:0] {
    CAUSE_NONE     = 3'd0,
    CAUSE_ABSENT   = 3'd1,
    CAUSE_TYPE     = 3'd2,
    CAUSE_PRIV     = 3'd3,
    CAUSE_LIMIT    = 3'd4,
    CAUSE_PG_USER  = 3'd5,
    CAUSE_PG_WRITE = 3'd6
  } cause_e;

  // segment class bit positions
  localparam int unsigned SEGT_SYS  = 2;
  localparam int unsigned SEGT_CODE = 1;
  localparam int unsigned SEGT_PERM = 0;

  localparam logic [1:0] RING_USER = 2'd3;

endpackage

// File: rtl/guard_limit_calc.sv
module guard_limit_calc #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned LIMIT_W = 20
) (
  input  logic [ADDR_W-1:0]  offset,
  input  logic [1:0]         len_m1,
  input  logic               gran,
  input  logic [LIMIT_W-1:0] limit,
  output logic               over
);
  localparam int unsigned SCALE_W = ADDR_W - LIMIT_W;

  logic [ADDR_W-1:0] eff_limit;
  logic [ADDR_W:0]   last_byte;

  generate
    if (SCALE_W > 0) begin : g_scaled
      always_comb begin
        if (gran) eff_limit = {limit, {SCALE_W{1'b1}}};
        else      eff_limit = {{SCALE_W{1'b0}}, limit};
      end
    end else begin : g_flat
      logic unused_gran;
      assign unused_gran = gran;
      assign eff_limit   = limit[ADDR_W-1:0];
    end
  endgenerate

  // one extra bit keeps a carry past the address top visible
  assign last_byte = {1'b0, offset} + {{(ADDR_W-1){1'b0}}, len_m1};
  assign over      = last_byte > {1'b0, eff_limit};

endmodule

// File: rtl/guard_seg_check.sv
module guard_seg_check
  import guard_pkg::*;
(
  input  logic [1:0] cpl,
  input  logic [1:0] rpl,
  input  logic [1:0] dpl,
  input  logic       present,
  input  logic [2:0] seg_type,
  input  logic [1:0] kind,
  input  logic       limit_over,
  output logic [2:0] cause
);
  logic [1:0] eff_ring;
  logic       type_bad;
  logic       is_code;
  logic       perm;

  assign eff_ring = (rpl > cpl) ? rpl : cpl;
  assign is_code  = seg_type[SEGT_CODE];
  assign perm     = seg_type[SEGT_PERM];

  always_comb begin
    type_bad = 1'b0;
    case (kind)
      ACC_READ:  type_bad = is_code & ~perm;
      ACC_WRITE: type_bad = is_code | ~perm;
      ACC_FETCH: type_bad = ~is_code;
      default:   type_bad = 1'b1;
    endcase
    if (seg_type[SEGT_SYS]) type_bad = 1'b1;
  end

  always_comb begin
    if (!present)             cause = CAUSE_ABSENT;
    else if (type_bad)        cause = CAUSE_TYPE;
    else if (eff_ring > dpl)  cause = CAUSE_PRIV;
    else if (limit_over)      cause = CAUSE_LIMIT;
    else                      cause = CAUSE_NONE;
  end

endmodule

// File: rtl/guard_page_check.sv
module guard_page_check
  import guard_pkg::*;
(
  input  logic [1:0] cpl,
  input  logic [1:0] kind,
  input  logic       pte_user,
  input  logic       pte_write,
  output logic [2:0] cause
);
  logic user_mode;

  assign user_mode = (cpl == RING_USER);

  always_comb begin
    if (user_mode && !pte_user)                         cause = CAUSE_PG_USER;
    else if (user_mode && kind == ACC_WRITE && !pte_write) cause = CAUSE_PG_WRITE;
    else                                                cause = CAUSE_NONE;
  end

endmodule

// File: rtl/seg_page_guard.sv
module seg_page_guard
  import guard_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned LIMIT_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [1:0]         req_cpl,
  input  logic [1:0]         req_rpl,
  input  logic [1:0]         seg_dpl,
  input  logic [2:0]         seg_type,
  input  logic               seg_present,
  input  logic               seg_gran,
  input  logic [LIMIT_W-1:0] seg_limit,
  input  logic [ADDR_W-1:0]  req_offset,
  input  logic [1:0]         req_len,
  input  logic [1:0]         req_kind,
  input  logic               paging_en,
  input  logic               pte_user,
  input  logic               pte_write,
  output logic               rsp_valid,
  output logic               rsp_grant,
  output logic [2:0]         rsp_cause
);
  // reset: asserted at once, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic       lim_over;
  logic [2:0] seg_cause;
  logic [2:0] pg_cause;
  logic [2:0] final_cause;

  guard_limit_calc #(.ADDR_W(ADDR_W), .LIMIT_W(LIMIT_W)) u_limit (
    .offset (req_offset),
    .len_m1 (req_len),
    .gran   (seg_gran),
    .limit  (seg_limit),
    .over   (lim_over)
  );

  guard_seg_check u_seg (
    .cpl        (req_cpl),
    .rpl        (req_rpl),
    .dpl        (seg_dpl),
    .present    (seg_present),
    .seg_type   (seg_type),
    .kind       (req_kind),
    .limit_over (lim_over),
    .cause      (seg_cause)
  );

  guard_page_check u_page (
    .cpl       (req_cpl),
    .kind      (req_kind),
    .pte_user  (pte_user),
    .pte_write (pte_write),
    .cause     (pg_cause)
  );

  always_comb begin
    if (seg_cause != CAUSE_NONE) final_cause = seg_cause;
    else if (paging_en)          final_cause = pg_cause;
    else                         final_cause = CAUSE_NONE;
  end

  // next state
  logic       valid_d;
  logic       grant_d;
  logic [2:0] cause_d;
  logic       ans_en;

  assign ans_en  = req_valid;
  assign valid_d = req_valid;
  assign grant_d = (final_cause == CAUSE_NONE);
  assign cause_d = final_cause;

  // registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) rsp_valid <= 1'b0;
    else             rsp_valid <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      rsp_grant <= 1'b0;
      rsp_cause <= CAUSE_NONE;
    end else if (ans_en) begin
      rsp_grant <= grant_d;
      rsp_cause <= cause_d;
    end
  end

endmodule

module seg_page_guard_chk (
  input logic       clk,
  input logic       rst_core_n,
  input logic       req_valid,
  input logic [1:0] req_cpl,
  input logic [1:0] req_rpl,
  input logic [1:0] seg_dpl,
  input logic [2:0] seg_type,
  input logic       seg_present,
  input logic [1:0] req_kind,
  input logic       paging_en,
  input logic       pte_user,
  input logic       rsp_valid,
  input logic       rsp_grant,
  input logic [2:0] rsp_cause
);
  assert_answer_R1: assert property (@(posedge clk) disable iff (!rst_core_n)
    req_valid |=> rsp_valid);

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_core_n)
    !req_valid |=> (!rsp_valid && $stable(rsp_cause) && $stable(rsp_grant)));

  assert_ring_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (req_valid && (req_cpl > seg_dpl || req_rpl > seg_dpl)) |=> !rsp_grant);

  assert_code_write_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (req_valid && req_kind == 2'd1 && seg_type[1]) |=> !rsp_grant);

  assert_absent_first_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (req_valid && !seg_present) |=> (rsp_cause == 3'd1));

  assert_user_page_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    (req_valid && paging_en && req_cpl == 2'd3 && !pte_user) |=> !rsp_grant);

  assert_paging_off_R10: assert property (@(posedge clk) disable iff (!rst_core_n)
    (req_valid && !paging_en) |=> (rsp_cause < 3'd5));

  assert_grant_cause_R11: assert property (@(posedge clk) disable iff (!rst_core_n)
    rsp_valid |-> (rsp_grant == (rsp_cause == 3'd0)));
endmodule

bind seg_page_guard seg_page_guard_chk u_chk (
  .clk         (clk),
  .rst_core_n  (rst_core_n),
  .req_valid   (req_valid),
  .req_cpl     (req_cpl),
  .req_rpl     (req_rpl),
  .seg_dpl     (seg_dpl),
  .seg_type    (seg_type),
  .seg_present (seg_present),
  .req_kind    (req_kind),
  .paging_en   (paging_en),
  .pte_user    (pte_user),
  .rsp_valid   (rsp_valid),
  .rsp_grant   (rsp_grant),
  .rsp_cause   (rsp_cause)
);

// File: tb/seg_page_guard_bench.sv
module seg_page_guard_bench;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_cpl, req_rpl, seg_dpl, req_len, req_kind;
  logic [2:0]  seg_type;
  logic        seg_present, seg_gran, paging_en, pte_user, pte_write;
  logic [19:0] seg_limit;
  logic [31:0] req_offset;
  logic        rsp_valid, rsp_grant;
  logic [2:0]  rsp_cause;

  // staged stimulus, copied onto the pins at a falling edge
  logic [1:0]  s_cpl, s_rpl, s_dpl, s_len, s_kind;
  logic [2:0]  s_type;
  logic        s_pres, s_gran, s_pg, s_user, s_wr;
  logic [19:0] s_limit;
  logic [31:0] s_off;

  int vectors;
  int miscompares;
  logic [4:0] exp_q[$];
  string      tag_q[$];
  logic       last_grant;
  logic [2:0] last_cause;

  seg_page_guard u_seg_page_guard (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .req_cpl(req_cpl), .req_rpl(req_rpl), .seg_dpl(seg_dpl),
    .seg_type(seg_type), .seg_present(seg_present), .seg_gran(seg_gran),
    .seg_limit(seg_limit), .req_offset(req_offset), .req_len(req_len),
    .req_kind(req_kind), .paging_en(paging_en), .pte_user(pte_user),
    .pte_write(pte_write), .rsp_valid(rsp_valid), .rsp_grant(rsp_grant),
    .rsp_cause(rsp_cause)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int model_cause();
    int epl;
    bit sys, code, perm, bad;
    longint unsigned eff, last;
    epl  = (s_rpl > s_cpl) ? int'(s_rpl) : int'(s_cpl);
    sys  = s_type[2]; code = s_type[1]; perm = s_type[0];
    case (s_kind)
      2'd0:    bad = code && !perm;
      2'd1:    bad = code || !perm;
      2'd2:    bad = !code;
      default: bad = 1'b1;
    endcase
    if (sys) bad = 1'b1;
    eff  = s_gran ? ((longint'(s_limit) << 12) | 64'hFFF) : longint'(s_limit);
    last = longint'(s_off) + longint'(s_len);
    if (!s_pres)              return 1;
    if (bad)                  return 2;
    if (epl > int'(s_dpl))    return 3;
    if (last > eff)           return 4;
    if (s_pg && s_cpl == 2'd3 && !s_user) return 5;
    if (s_pg && s_cpl == 2'd3 && s_kind == 2'd1 && !s_wr) return 6;
    return 0;
  endfunction

  function automatic string cause_tag(int c);
    case (c)
      1: return "R6";
      2: return "R3";
      3: return "R2";
      4: return "R4";
      5: return "R8";
      6: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic compare_now();
    logic [4:0] e;
    string      t;
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    vectors++;
    if (rsp_valid !== e[4]) begin
      miscompares++;
      $display("FAIL %s rsp_valid actual=%0b expected=%0b", t, rsp_valid, e[4]);
    end
    if (rsp_grant !== e[3]) begin
      miscompares++;
      $display("FAIL %s rsp_grant actual=%0b expected=%0b", t, rsp_grant, e[3]);
    end
    if (rsp_cause !== e[2:0]) begin
      miscompares++;
      $display("FAIL %s rsp_cause actual=%0d expected=%0d", t, rsp_cause, e[2:0]);
    end
  endtask

  // one clock: check the answer due now, then present the next input
  task automatic cycle(input bit v, input string tag);
    int c;
    @(negedge clk);
    compare_now();
    req_valid = v;
    req_cpl = s_cpl; req_rpl = s_rpl; seg_dpl = s_dpl; seg_type = s_type;
    seg_present = s_pres; seg_gran = s_gran; seg_limit = s_limit;
    req_offset = s_off; req_len = s_len; req_kind = s_kind;
    paging_en = s_pg; pte_user = s_user; pte_write = s_wr;
    if (v) begin
      c = model_cause();
      last_grant = (c == 0);
      last_cause = 3'(c);
      exp_q.push_back({1'b1, last_grant, last_cause});
      tag_q.push_back((tag == "") ? cause_tag(c) : tag);
    end else begin
      exp_q.push_back({1'b0, last_grant, last_cause});
      tag_q.push_back((tag == "") ? "R1" : tag);
    end
  endtask

  task automatic base_data();
    s_cpl = 2'd0; s_rpl = 2'd0; s_dpl = 2'd3; s_type = 3'b001;
    s_pres = 1'b1; s_gran = 1'b0; s_limit = 20'h00FFF; s_off = 32'h10;
    s_len = 2'd0; s_kind = 2'd0; s_pg = 1'b0; s_user = 1'b1; s_wr = 1'b1;
  endtask

  initial begin
    vectors = 0; miscompares = 0;
    last_grant = 1'b0; last_cause = 3'd0;
    req_valid = 1'b0;
    base_data();
    req_cpl = 0; req_rpl = 0; seg_dpl = 0; seg_type = 0; seg_present = 0;
    seg_gran = 0; seg_limit = 0; req_offset = 0; req_len = 0; req_kind = 0;
    paging_en = 0; pte_user = 0; pte_write = 0;
    rst_n = 1'b0;
    exp_q.push_back(5'b0); tag_q.push_back("R11");
    repeat (3) cycle(1'b0, "R11");
    rst_n = 1'b1;
    repeat (4) cycle(1'b0, "R11");

    // R2: selector ring less trusted than running ring
    base_data(); s_cpl = 0; s_rpl = 3; s_dpl = 2; cycle(1'b1, "R2");
    s_rpl = 2; cycle(1'b1, "R2");
    s_cpl = 3; s_rpl = 0; cycle(1'b1, "R2");
    // R3: class rules
    base_data(); s_type = 3'b000; s_kind = 2'd1; cycle(1'b1, "R3");
    s_kind = 2'd2; cycle(1'b1, "R3");
    s_type = 3'b010; s_kind = 2'd0; cycle(1'b1, "R3");
    s_type = 3'b011; s_kind = 2'd1; cycle(1'b1, "R3");
    s_kind = 2'd2; cycle(1'b1, "R3");
    s_type = 3'b101; s_kind = 2'd0; cycle(1'b1, "R3");
    s_type = 3'b001; s_kind = 2'd3; cycle(1'b1, "R3");
    // R4: byte limit edges
    base_data(); s_limit = 20'h00100; s_off = 32'h100; cycle(1'b1, "R4");
    s_len = 2'd1; cycle(1'b1, "R4");
    s_off = 32'hFD; s_len = 2'd3; cycle(1'b1, "R4");
    s_off = 32'hFE; cycle(1'b1, "R4");
    // R5: scaled limit edges and carry out of the top
    base_data(); s_gran = 1; s_limit = 20'h00001; s_off = 32'h1FFF; cycle(1'b1, "R5");
    s_len = 2'd1; cycle(1'b1, "R5");
    s_limit = 20'hFFFFF; s_off = 32'hFFFFFFFF; s_len = 2'd0; cycle(1'b1, "R5");
    s_len = 2'd1; cycle(1'b1, "R5");
    // R6 / R7: fault ranking
    base_data(); s_pres = 0; s_off = 32'hFFFFF; s_type = 3'b100; cycle(1'b1, "R6");
    base_data(); s_type = 3'b000; s_kind = 2'd1; s_cpl = 3; s_dpl = 0; cycle(1'b1, "R7");
    base_data(); s_cpl = 3; s_dpl = 0; s_off = 32'hFFFFF; cycle(1'b1, "R7");
    base_data(); s_off = 32'hFFFFF; s_pg = 1; s_cpl = 3; s_user = 0; cycle(1'b1, "R7");
    // R8 / R9: page rules
    base_data(); s_pg = 1; s_cpl = 3; s_user = 0; cycle(1'b1, "R8");
    s_cpl = 2; cycle(1'b1, "R8");
    base_data(); s_pg = 1; s_cpl = 3; s_kind = 2'd1; s_wr = 0; cycle(1'b1, "R9");
    s_cpl = 0; cycle(1'b1, "R9");
    s_cpl = 3; s_kind = 2'd0; cycle(1'b1, "R9");
    // R10: paging off ignores page flags
    base_data(); s_pg = 0; s_cpl = 3; s_user = 0; s_wr = 0; s_kind = 2'd1; cycle(1'b1, "R10");
    // R1: idle cycles keep the last answer
    cycle(1'b0, "R1"); cycle(1'b0, "R1");

    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      s_cpl = 2'($urandom); s_rpl = 2'($urandom); s_dpl = 2'($urandom);
      s_type = 3'($urandom); s_pres = ($urandom % 8) != 0; s_gran = 1'($urandom);
      s_limit = 20'($urandom % 64); s_off = ($urandom % 2) ? 32'($urandom % 300000)
                                                            : 32'($urandom);
      s_len = 2'($urandom); s_kind = 2'($urandom); s_pg = 1'($urandom);
      s_user = 1'($urandom); s_wr = 1'($urandom);
      cycle(($urandom % 4) != 0, "");
    end
    cycle(1'b0, "R1");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #1000000;
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule